// File: doc/BRIEF.md
# Integration Test Output Override and FIFO Test Port

This block is the test-control corner of a smart-card interface peripheral. Software reaches it through a small 16-bit register bus that has a single-cycle write strobe, a read strobe and a combinational read path selected by a word address. A control register holds two enables. The first is integration-test mode. While it is set, every intra-chip output and every primary pin output of the peripheral takes its value from a bit of the override register instead of from the functional logic. A per-signal multiplexer does the switching.

Read-back of the override register depends on the bit class. The four intra-chip bits return the live value seen after their multiplexer, so software sees the functional value while test mode is off. The nine primary-output bits always return the value last stored. The second enable turns on FIFO test. In that mode the test data register runs opposite to normal traffic: a bus write pushes a word into the receive FIFO, and a bus read shows and pops the head of the transmit FIFO. The protocol engine is not part of this block. Its outputs enter as functional inputs, and the FIFOs' far sides are plain ports.

Top module: `itest_out_ctrl`

## Requirements
- R1: After reset, both control enables are 0, the override register is all zeros, and both FIFOs are empty (`rxq_empty`=1, `rxq_data`=0, `txq_full`=0).
- R2: While integration-test mode is 0, `pin_out` equals `fn_prim` and `intra_out` equals `fn_intra`, whatever the override register holds.
- R3: While integration-test mode is 1, `pin_out[8:0]` equals override bits 8:0 and `intra_out[3:0]` equals override bits 12:9 (bit 12 to `intra_out[3]`). Override writes take effect on the outputs in the cycle after the write edge.
- R4: A read at address 1 (override register) returns `intra_out` in bits 12:9 and zero in bits 15:13.
- R5: A read at address 1 returns, in bits 8:0, the value last written to those bits, in either mode.
- R6: Address 0 is the control register: bit 0 is integration-test mode and bit 1 is FIFO test. A read returns those two bits with all other bits zero.
- R7: While FIFO test is 1, a write at address 2 pushes `bus_wdata` into the receive FIFO. `rxq_data` shows the oldest word, and `rxq_pop` removes it in first-in first-out order.
- R8: While FIFO test is 1, a read at address 2 returns the oldest transmit-FIFO word, and `bus_rd` at address 2 pops it.
- R9: While FIFO test is 0, writes at address 2 leave the receive FIFO unchanged, and reads at address 2 return 0 without popping the transmit FIFO.
- R10: A push to a full FIFO (depth `RX_DEPTH`/`TX_DEPTH`, default 4) is discarded, and a pop from an empty one is discarded. A read at address 2 of an empty transmit FIFO returns 0.
- R11: Address 3 reads as zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at the test data address) |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| fn_intra | input | 4 | Functional intra-chip outputs (interrupt, clock-active, clock-stop, overrun; bit 3 down to 0) |
| fn_prim | input | 9 | Functional primary outputs (bit 8 down to 0) |
| intra_out | output | 4 | Intra-chip outputs after the test multiplexers |
| pin_out | output | 9 | Primary outputs after the test multiplexers |
| rxq_pop | input | 1 | Receive FIFO pop from the engine side |
| rxq_data | output | DATA_W | Receive FIFO head, 0 when empty |
| rxq_empty | output | 1 | Receive FIFO empty |
| txq_push | input | 1 | Transmit FIFO push from the engine side |
| txq_wdata | input | DATA_W | Transmit FIFO push data |
| txq_full | output | 1 | Transmit FIFO full |

## Verification
The functional inputs are driven with complementary patterns (0x1A5/0xA and 0x05A/0x5), and the override register is loaded with all-ones, 0x1555 and 0x0AAA in both modes. This shows whether each output bit follows the right source, and a swapped or crossed bit index shows up as a mismatch. Read-back is tried with the two sources set to differ, so returning the stored intra-chip bits instead of the post-multiplexer value, or returning the live primary pins instead of the stored bits, produces a wrong word. The FIFO tests push past full, pop past empty, issue simultaneous push and pop, and repeat the test data accesses with FIFO test off. These cases separate a correct gate from one that leaks, overwrites or drops order.

// File: rtl/itest_pkg.sv
package itest_pkg;
   localparam int INTRA_N  = 4;
   localparam int PRIM_N   = 9;
   localparam int OVR_USED = INTRA_N + PRIM_N;
   localparam int ITM_BIT  = 0;
   localparam int FIFO_BIT = 1;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_OVR   = 2'd1,
      SEL_TDATA = 2'd2,
      SEL_SPARE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/itest_regs.sv
module itest_regs
   import itest_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  reg_sel_e            sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic                itm_en,
   output logic                fifo_en,
   output logic [OVR_USED-1:0] ovr_q
);
   wire unused_hi = ^wdata[DATA_W-1:OVR_USED];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         itm_en  <= 1'b0;
         fifo_en <= 1'b0;
         ovr_q   <= '0;
      end else if (wr) begin
         case (sel)
            SEL_CTRL: begin
               itm_en  <= wdata[ITM_BIT];
               fifo_en <= wdata[FIFO_BIT];
            end
            SEL_OVR:  ovr_q <= wdata[OVR_USED-1:0];
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/itest_mux_bank.sv
module itest_mux_bank #(
   parameter int WIDTH   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_test,
   input  logic [WIDTH-1:0] fn_in,
   input  logic [WIDTH-1:0] test_in,
   output logic [WIDTH-1:0] out
);
   if (WIDTH < 1) begin : g_bad_width
      $error("itest_mux_bank: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (REG_OUT) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= sel_test ? test_in[i] : fn_in[i];
         end
         assign out[i] = q;
      end else begin : g_comb
         assign out[i] = sel_test ? test_in[i] : fn_in[i];
      end
   end

   if (!REG_OUT) begin : g_noclk
      wire unused_ck = clk ^ rst_n;
   end
endmodule

// File: rtl/itest_fifo.sv
module itest_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("itest_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + PW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + PW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/itest_out_ctrl.sv
module itest_out_ctrl
   import itest_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 16,
   parameter int RX_DEPTH = 4,
   parameter int TX_DEPTH = 4,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [INTRA_N-1:0] fn_intra,
   input  logic [PRIM_N-1:0]  fn_prim,
   output logic [INTRA_N-1:0] intra_out,
   output logic [PRIM_N-1:0]  pin_out,
   input  logic               rxq_pop,
   output logic [DATA_W-1:0]  rxq_data,
   output logic               rxq_empty,
   input  logic               txq_push,
   input  logic [DATA_W-1:0]  txq_wdata,
   output logic               txq_full
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("itest_out_ctrl: ADDR_W must be at least 2");
   end
   if (DATA_W < OVR_USED + 1) begin : g_bad_data
      $error("itest_out_ctrl: DATA_W too narrow for the override register");
   end

   logic                hi_zero;
   reg_sel_e            sel;
   logic                itm_en, fifo_en;
   logic [OVR_USED-1:0] ovr_q;
   logic                rx_full, tx_empty;
   logic [DATA_W-1:0]   tx_dout;
   logic                tdata_hit;

   if (ADDR_W > 2) begin : g_wide_addr
      assign hi_zero = (bus_addr[ADDR_W-1:2] == '0);
   end else begin : g_narrow_addr
      assign hi_zero = 1'b1;
   end

   assign sel       = hi_zero ? reg_sel_e'(bus_addr[1:0]) : SEL_SPARE;
   assign tdata_hit = (sel == SEL_TDATA) && fifo_en;

   itest_regs #(.DATA_W(DATA_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .itm_en  (itm_en),
      .fifo_en (fifo_en),
      .ovr_q   (ovr_q)
   );

   itest_mux_bank #(.WIDTH(INTRA_N), .REG_OUT(REG_OUT)) intra_mux_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_test (itm_en),
      .fn_in    (fn_intra),
      .test_in  (ovr_q[OVR_USED-1:PRIM_N]),
      .out      (intra_out)
   );

   itest_mux_bank #(.WIDTH(PRIM_N), .REG_OUT(REG_OUT)) prim_mux_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_test (itm_en),
      .fn_in    (fn_prim),
      .test_in  (ovr_q[PRIM_N-1:0]),
      .out      (pin_out)
   );

   itest_fifo #(.DW(DATA_W), .DEPTH(RX_DEPTH)) rx_fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (bus_wr && tdata_hit),
      .din   (bus_wdata),
      .pop   (rxq_pop),
      .dout  (rxq_data),
      .full  (rx_full),
      .empty (rxq_empty)
   );

   itest_fifo #(.DW(DATA_W), .DEPTH(TX_DEPTH)) tx_fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (txq_push),
      .din   (txq_wdata),
      .pop   (bus_rd && tdata_hit),
      .dout  (tx_dout),
      .full  (txq_full),
      .empty (tx_empty)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_CTRL: begin
            bus_rdata[ITM_BIT]  = itm_en;
            bus_rdata[FIFO_BIT] = fifo_en;
         end
         SEL_OVR: begin
            bus_rdata[OVR_USED-1:PRIM_N] = intra_out;
            bus_rdata[PRIM_N-1:0]        = ovr_q[PRIM_N-1:0];
         end
         SEL_TDATA: bus_rdata = fifo_en ? tx_dout : '0;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/itest_out_ctrl_chk.sv
module itest_out_ctrl_chk
   import itest_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [INTRA_N-1:0]  fn_intra,
   input logic [PRIM_N-1:0]   fn_prim,
   input logic [INTRA_N-1:0]  intra_out,
   input logic [PRIM_N-1:0]   pin_out,
   input logic                rxq_pop,
   input logic                rxq_empty,
   input logic                txq_push,
   input logic                itm_en,
   input logic                fifo_en,
   input logic [OVR_USED-1:0] ovr_q,
   input logic                rx_full,
   input logic                tx_empty
);
   logic at_ctrl, at_ovr, at_tdata;
   assign at_ctrl  = (bus_addr == ADDR_W'(0));
   assign at_ovr   = (bus_addr == ADDR_W'(1));
   assign at_tdata = (bus_addr == ADDR_W'(2));

   if (!REG_OUT) begin : g_comb_checks
      AST_PASS_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
         !itm_en |-> pin_out == fn_prim);                               // R2
      AST_PASS_INTRA: assert property (@(posedge clk) disable iff (!rst_n)
         !itm_en |-> intra_out == fn_intra);                            // R2
      AST_OVR_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && at_ovr) |=> (!itm_en || pin_out == $past(bus_wdata[PRIM_N-1:0]))); // R3
   end

   AST_INTRA_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      at_ovr |-> bus_rdata[OVR_USED-1:PRIM_N] == intra_out);            // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      at_ovr |-> bus_rdata[DATA_W-1:OVR_USED] == '0);                   // R4
   AST_PRIM_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_ovr) |=> (!at_ovr || bus_rdata[PRIM_N-1:0] == $past(bus_wdata[PRIM_N-1:0]))); // R5
   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_ctrl) |=> (itm_en == $past(bus_wdata[ITM_BIT]) && fifo_en == $past(bus_wdata[FIFO_BIT]))); // R6
   AST_RX_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && bus_wr && at_tdata && rxq_empty && !rxq_pop) |=> !rxq_empty); // R7
   AST_TDATA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && at_tdata) |-> bus_rdata == '0);                       // R9
   AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && rxq_empty) |=> rxq_empty);                            // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rxq_pop) |=> rx_full);                                // R10
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !txq_push) |=> tx_empty);                             // R10
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $rose(rst_n) |-> (!itm_en && !fifo_en && ovr_q == '0 && rxq_empty)); // R1
endmodule

bind itest_out_ctrl itest_out_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .REG_OUT (REG_OUT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .fn_intra  (fn_intra),
   .fn_prim   (fn_prim),
   .intra_out (intra_out),
   .pin_out   (pin_out),
   .rxq_pop   (rxq_pop),
   .rxq_empty (rxq_empty),
   .txq_push  (txq_push),
   .itm_en    (itm_en),
   .fifo_en   (fifo_en),
   .ovr_q     (ovr_q),
   .rx_full   (rx_full),
   .tx_empty  (tx_empty)
);

// File: tb/itest_out_ctrl_tb_top.sv
module itest_out_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr = 1'b0, b_rd = 1'b0;
   logic [1:0]  b_addr = '0;
   logic [15:0] b_wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  f_intra = '0, intra_out;
   logic [8:0]  f_prim = '0, pin_out;
   logic        r_pop = 1'b0, rx_empty;
   logic [15:0] rx_data;
   logic        t_push = 1'b0, tx_full;
   logic [15:0] t_wdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   itest_out_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
      .bus_wdata(b_wdata), .bus_rdata(rdata), .fn_intra(f_intra), .fn_prim(f_prim),
      .intra_out(intra_out), .pin_out(pin_out), .rxq_pop(r_pop), .rxq_data(rx_data),
      .rxq_empty(rx_empty), .txq_push(t_push), .txq_wdata(t_wdata), .txq_full(tx_full)
   );

   // behavioural reference state
   bit          m_itm, m_fe;
   logic [12:0] m_ovr;
   logic [15:0] rx_q[$];
   logic [15:0] tx_q[$];

   int    n_checks = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_intra();
      return m_itm ? m_ovr[12:9] : f_intra;
   endfunction

   function automatic logic [15:0] exp_rdata();
      case (b_addr)
         2'd0: return {14'd0, m_fe, m_itm};
         2'd1: return {3'd0, exp_intra(), m_ovr[8:0]};
         2'd2: return (m_fe && tx_q.size() > 0) ? tx_q[0] : 16'd0;
         default: return 16'd0;
      endcase
   endfunction

   task automatic compare_all();
      cmp("pin_out",   {7'd0, pin_out}, {7'd0, m_itm ? m_ovr[8:0] : f_prim});
      cmp("intra_out", {12'd0, intra_out}, {12'd0, exp_intra()});
      cmp("bus_rdata", rdata, exp_rdata());
      cmp("rxq_data",  rx_data, rx_q.size() > 0 ? rx_q[0] : 16'd0);
      cmp("rxq_empty", {15'd0, rx_empty}, {15'd0, rx_q.size() == 0});
      cmp("txq_full",  {15'd0, tx_full}, {15'd0, tx_q.size() == DEPTH});
   endtask

   task automatic model_update();
      bit rx_pop_ok, rx_push_ok, tx_pop_ok, tx_push_ok;
      if (!rst_n) begin
         m_itm = 0; m_fe = 0; m_ovr = '0;
         rx_q.delete(); tx_q.delete();
         return;
      end
      rx_pop_ok  = r_pop && rx_q.size() > 0;
      rx_push_ok = b_wr && b_addr == 2'd2 && m_fe && rx_q.size() < DEPTH;
      tx_pop_ok  = b_rd && b_addr == 2'd2 && m_fe && tx_q.size() > 0;
      tx_push_ok = t_push && tx_q.size() < DEPTH;
      if (rx_pop_ok)  void'(rx_q.pop_front());
      if (rx_push_ok) rx_q.push_back(b_wdata);
      if (tx_pop_ok)  void'(tx_q.pop_front());
      if (tx_push_ok) tx_q.push_back(t_wdata);
      if (b_wr && b_addr == 2'd0) begin m_itm = b_wdata[0]; m_fe = b_wdata[1]; end
      if (b_wr && b_addr == 2'd1) m_ovr = b_wdata[12:0];
   endtask

   // inputs are set at the falling edge; outputs compared 1 time unit later
   task automatic step();
      #1 compare_all();
      @(posedge clk);
      model_update();
      @(negedge clk);
      b_wr = 0; b_rd = 0; r_pop = 0; t_push = 0;
   endtask

   task automatic bwrite(logic [1:0] a, logic [15:0] d);
      b_addr = a; b_wdata = d; b_wr = 1; step();
   endtask

   task automatic bread(logic [1:0] a, bit strobe);
      b_addr = a; b_rd = strobe; step();
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      @(negedge clk);
      model_update();
      // R1: reset state
      cur_req = "R1";
      repeat (2) step();
      rst_n = 1;
      bread(2'd0, 0); bread(2'd1, 0); bread(2'd2, 1);

      // R2: functional pass-through, override loaded but not selected
      cur_req = "R2";
      f_prim = 9'h1A5; f_intra = 4'hA; step();
      bwrite(2'd1, 16'hFFFF);
      f_prim = 9'h05A; f_intra = 4'h5; step();
      // R4 R5: readback with test mode off -> intra from functional, prim stored
      cur_req = "R4"; bread(2'd1, 0);
      cur_req = "R5"; f_intra = 4'hC; bread(2'd1, 0);

      // R6: control register
      cur_req = "R6";
      bwrite(2'd0, 16'hFFFD); bread(2'd0, 0);
      bwrite(2'd0, 16'h0000); bwrite(2'd0, 16'h0003); bread(2'd0, 0);

      // R3: override selected
      cur_req = "R3";
      bwrite(2'd1, 16'h1555); step();
      bwrite(2'd1, 16'hE0AA); step();
      f_prim = 9'h1FF; f_intra = 4'hF; bwrite(2'd1, 16'h0AAA);
      cur_req = "R4"; bread(2'd1, 0);
      cur_req = "R5"; bwrite(2'd0, 16'h0002); bread(2'd1, 0);

      // R7: receive FIFO push via test data
      cur_req = "R7";
      bwrite(2'd2, 16'h1111); bwrite(2'd2, 16'h2222); bwrite(2'd2, 16'h3333);
      r_pop = 1; step();
      r_pop = 1; b_addr = 2'd2; b_wdata = 16'h4444; b_wr = 1; step();
      // R10: fill beyond depth
      cur_req = "R10";
      bwrite(2'd2, 16'h5555); bwrite(2'd2, 16'h6666); bwrite(2'd2, 16'h7777);
      repeat (5) begin r_pop = 1; step(); end

      // R8: transmit FIFO read via test data
      cur_req = "R8";
      t_wdata = 16'hA001; t_push = 1; step();
      t_wdata = 16'hA002; t_push = 1; step();
      bread(2'd2, 0); bread(2'd2, 1); bread(2'd2, 1);
      cur_req = "R10";
      bread(2'd2, 1);
      for (int i = 0; i < 6; i++) begin t_wdata = 16'hB000 + 16'(i); t_push = 1; step(); end

      // R9: FIFO test disabled
      cur_req = "R9";
      bwrite(2'd0, 16'h0001);
      bwrite(2'd2, 16'hDEAD); bread(2'd2, 1); bread(2'd2, 1);
      bwrite(2'd0, 16'h0002); bread(2'd2, 1);

      // R11: spare address
      cur_req = "R11";
      bwrite(2'd3, 16'hFFFF); bread(2'd3, 0); bread(2'd0, 0); bread(2'd1, 0);

      done = 1;
      report();
   end
endmodule